// File: doc/BRIEF.md
# Serial DAC Input Register

This block is the digital front end of a 10-bit voltage-output converter. A host writes a new code over three wires: an active-low chip select, a serial clock and serial data. Each write is a 16-bit frame. While chip select is low, every rising serial-clock edge shifts one data bit into a 16-bit shift register. When chip select returns high, the 10 code bits are taken from that register into a parallel DAC holding register. The block then raises a one-cycle update strobe, which tells the analogue stage that a new code is present.

The frame is sent first bit to last in three parts:

- four fill bits;
- the ten code bits, most significant first;
- two sub-LSB bits.

Only the code reaches the holding register. The fill bits let several devices share one chip select in a chain. The sub-LSB bits keep the frame the same length as the one used by a 12-bit converter. A serial data output, driven from the end of the shift register, feeds the next device in the chain.

All three serial inputs are brought into the system clock domain through a synchroniser. Their edges are then found by comparing each synchronised value with its value one cycle earlier.

Top module: `sdac_input_reg`

## Requirements
- R1: After reset the code output is 0, the update strobe is 0 and the serial output is 0.
- R2: On a rising edge of chip select, the code output takes the ten bits sent in frame positions 5 to 14 (first bit sent is position 1), the first of these being the code MSB. In the shift register these are bits 11:2.
- R3: The values of the four fill bits (positions 1 to 4) have no effect on the latched code.
- R4: The two sub-LSB bits (positions 15 and 16) have no effect on the latched code, even when they are not zero.
- R5: Serial clock edges while chip select is high leave the shift register and the serial output unchanged.
- R6: The code output changes only in the cycle of an update. It holds its value while a new frame is being shifted in.
- R7: Each rising edge of chip select produces exactly one update-strobe cycle. The strobe is high in the third system clock cycle after the edge and low in the cycles before and after it. The code output changes in that same cycle. A repeated, unchanged code still produces a strobe.
- R8: The serial output is the MSB of the shift register. It is updated on falling serial-clock edges while chip select is low, so it repeats the serial input 16 serial clocks later.
- R9: When more than 16 bits are clocked in during one chip-select low period, the last 16 bits decide the latched code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select, asynchronous to clk |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sdi | input | 1 | Serial data in, sampled on rising sclk |
| sdo | output | 1 | Serial data out to the next device in a chain |
| dacCode | output | 10 | Registered DAC code |
| updValid | output | 1 | One-cycle strobe marking a new code |

## Verification
Each serial input passes through two synchroniser flops before the edge compare, so every result follows its input by three system clock rising edges:

- a rising edge of chip select updates the code and raises the strobe at the third rising edge;
- a falling serial-clock edge updates the serial output at the third rising edge.

The bench changes inputs on falling clock edges. It holds each serial-clock phase for four system clocks, which is longer than that latency. Around a chip-select release it samples one nanosecond after the second, third and fourth rising edges, expecting the strobe low, then high with the new code, then low again. The serial output is captured at the moment the bench raises the serial clock, as a downstream device would capture it.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  // Strobes from the control module to the datapath, one system cycle wide
  typedef struct packed {
    logic shiftEn;  // synchronised rising sclk while selected
    logic outEn;    // synchronised falling sclk while selected
    logic latch;    // synchronised rising chip select
  } strobeT;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   csN,
  input  logic   sclk,
  input  logic   sdi,
  output strobeT strb,
  output logic   csS,
  output logic   sdiS
);
  logic [2:0] synced;
  logic       sclkS;
  logic       csPrev;
  logic       sclkPrev;

  // Deselected, clock low, data low at reset
  sdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
    .clk (clk),
    .rstN(rstN),
    .d   ({csN, sclk, sdi}),
    .q   (synced)
  );

  assign csS   = synced[2];
  assign sclkS = synced[1];
  assign sdiS  = synced[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  always_comb begin
    strb.shiftEn = sclkS & ~sclkPrev & ~csS;
    strb.outEn   = ~sclkS & sclkPrev & ~csS;
    strb.latch   = csS & ~csPrev;
  end
endmodule

// File: rtl/sdac_dp.sv
module sdac_dp
  import sdac_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int CODE_W  = 10,
  parameter int SUB_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strb,
  input  logic               sdiS,
  output logic [FRAME_W-1:0] shiftReg,
  output logic [CODE_W-1:0]  dacCode,
  output logic               updValid,
  output logic               sdo
);
  localparam int CODE_LSB = SUB_W;
  localparam int CODE_MSB = SUB_W + CODE_W - 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      dacCode  <= '0;
      updValid <= 1'b0;
      sdo      <= 1'b0;
    end else begin
      updValid <= strb.latch;
      if (strb.shiftEn) shiftReg <= {shiftReg[FRAME_W-2:0], sdiS};
      if (strb.outEn)   sdo      <= shiftReg[FRAME_W-1];
      if (strb.latch)   dacCode  <= shiftReg[CODE_MSB:CODE_LSB];
    end
  end
endmodule

// File: rtl/sdac_input_reg.sv
module sdac_input_reg
  import sdac_pkg::*;
#(
  parameter int FILL_W      = 4,
  parameter int CODE_W      = 10,
  parameter int SUB_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic [CODE_W-1:0] dacCode,
  output logic              updValid
);
  localparam int FRAME_W = FILL_W + CODE_W + SUB_W;

  strobeT             strb;
  logic               csS;
  logic               sdiS;
  logic [FRAME_W-1:0] shiftReg;

  sdac_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk (clk),
    .rstN(rstN),
    .csN (csN),
    .sclk(sclk),
    .sdi (sdi),
    .strb(strb),
    .csS (csS),
    .sdiS(sdiS)
  );

  sdac_dp #(.FRAME_W(FRAME_W), .CODE_W(CODE_W), .SUB_W(SUB_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .sdiS    (sdiS),
    .shiftReg(shiftReg),
    .dacCode (dacCode),
    .updValid(updValid),
    .sdo     (sdo)
  );
endmodule

// File: rtl/sdac_input_reg_chk.sv
module sdac_input_reg_chk
  import sdac_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int CODE_W  = 10
) (
  input logic               clk,
  input logic               rstN,
  input strobeT             strb,
  input logic               csS,
  input logic [FRAME_W-1:0] shiftReg,
  input logic [CODE_W-1:0]  dacCode,
  input logic               updValid,
  input logic               sdo
);
  // R7
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> !updValid);

  // R2
  upd_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> $past(strb.latch));

  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dacCode != $past(dacCode)) |-> updValid);

  // R5
  shift_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> $stable(shiftReg));

  // R8
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdo != $past(sdo)) |-> $past(strb.outEn));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.shiftEn && strb.latch));
endmodule

bind sdac_input_reg sdac_input_reg_chk #(.FRAME_W(FRAME_W), .CODE_W(CODE_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .strb    (strb),
  .csS     (csS),
  .shiftReg(shiftReg),
  .dacCode (dacCode),
  .updValid(updValid),
  .sdo     (sdo)
);

// File: tb/sdac_input_reg_tb_top.sv
`timescale 1ns/1ps
module sdac_input_reg_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic       sdo;
  logic [9:0] dacCode;
  logic       updValid;

  int          checks = 0;
  int          fails = 0;
  logic [31:0] capt = '0;

  always #5 clk = ~clk;

  sdac_input_reg dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .sclk    (sclk),
    .sdi     (sdi),
    .sdo     (sdo),
    .dacCode (dacCode),
    .updValid(updValid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mkFrame(input logic [3:0] fill, input logic [9:0] code,
                                          input logic [1:0] sub);
    return {fill, code, sub};
  endfunction

  // One serial bit: data set while sclk low, rise (downstream capture), fall
  task automatic sendBit(input logic b);
    @(negedge clk); sdi = b;
    waitClk(4);
    sclk = 1'b1;
    capt = {capt[30:0], sdo};
    waitClk(4);
    sclk = 1'b0;
    waitClk(4);
  endtask

  task automatic sendWord(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic selectLow;
    @(negedge clk); csN = 1'b0;
    waitClk(4);
  endtask

  // Release chip select and check strobe timing and latched code (R7)
  task automatic releaseCheck(input string req, input logic [9:0] expCode);
    @(negedge clk); csN = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk({req, " R7 strobe early"}, updValid, 0);
    @(posedge clk);
    #1 chk({req, " R7 strobe"}, updValid, 1);
    chk(req, dacCode, expCode);
    @(posedge clk);
    #1 chk({req, " R7 strobe width"}, updValid, 0);
    waitClk(4);
  endtask

  task automatic writeFrame(input string req, input logic [15:0] w, input logic [9:0] expCode);
    selectLow();
    sendWord(w);
    releaseCheck(req, expCode);
  endtask

  task automatic testReset;
    #1;
    chk("R1 code", dacCode, 0);
    chk("R1 strobe", updValid, 0);
    chk("R1 sdo", sdo, 0);
  endtask

  task automatic testBasic;
    writeFrame("R2 basic", mkFrame(4'h0, 10'h2A5, 2'b00), 10'h2A5);
    writeFrame("R2 alt", mkFrame(4'h0, 10'h15A, 2'b00), 10'h15A);
    writeFrame("R7 repeat", mkFrame(4'h0, 10'h15A, 2'b00), 10'h15A);
  endtask

  task automatic testFill;
    writeFrame("R3 fill ones", mkFrame(4'hF, 10'h0C3, 2'b00), 10'h0C3);
    writeFrame("R3 fill mixed", mkFrame(4'hA, 10'h3FF, 2'b00), 10'h3FF);
  endtask

  task automatic testSub;
    writeFrame("R4 sub ones", mkFrame(4'h0, 10'h001, 2'b11), 10'h001);
    writeFrame("R4 sub one zero code", mkFrame(4'h5, 10'h000, 2'b10), 10'h000);
  endtask

  task automatic testHold;
    logic [15:0] w;
    w = mkFrame(4'h0, 10'h1E7, 2'b00);
    selectLow();
    for (int i = 15; i >= 8; i--) sendBit(w[i]);
    chk("R6 hold mid frame", dacCode, 10'h000);
    chk("R6 no strobe mid frame", updValid, 0);
    for (int i = 7; i >= 0; i--) sendBit(w[i]);
    releaseCheck("R6 after frame", 10'h1E7);
  endtask

  task automatic testDeselectedClock;
    logic sdoBefore;
    writeFrame("R5 setup", mkFrame(4'h0, 10'h24B, 2'b00), 10'h24B);
    sdoBefore = sdo;
    for (int i = 0; i < 16; i++) sendBit(1'b1);  // csN stays high
    chk("R5 code unchanged", dacCode, 10'h24B);
    chk("R5 sdo unchanged", sdo, sdoBefore);
    selectLow();
    releaseCheck("R5 shift register unchanged", 10'h24B);
  endtask

  task automatic testChain;
    logic [15:0] a;
    logic [15:0] b;
    a = mkFrame(4'h9, 10'h35C, 2'b01);
    b = mkFrame(4'h6, 10'h0A3, 2'b00);
    capt = '0;
    selectLow();
    sendWord(a);
    sendWord(b);
    chk("R8 sdo delayed by 16", capt[15:0], a);
    releaseCheck("R9 last 16 bits", 10'h0A3);
  endtask

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);
    testReset();
    testBasic();
    testFill();
    testSub();
    testHold();
    testDeselectedClock();
    testChain();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule